// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Speech Source

This block gathers the interrupt sources of a small 8-bit CPU subsystem and decides when the core must be interrupted and where it should jump. Four internal peripherals (a basic timer, two timer/counters and a watch timer) each deliver a one-cycle request pulse. A speech-synthesis engine delivers a request that can never be masked. Three external pins carry active-low requests that are synchronised and caught on their falling edge. Every request sets a pending flag. The flag stays set until software clears it by writing a one to it.

The seven maskable sources need both their own enable bit and a global enable before they reach the CPU. All seven share a single entry address, so the service routine polls the pending flags to find out which source fired. The speech source ignores every enable and has its own entry address, and it wins over the shared group. When the CPU acknowledges an interrupt, the global enable is dropped. Once a speech interrupt is acknowledged, it is held off until software clears its flag, so the core does not loop on it.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, all pending flags, all per-source enables and the global enable read 0. `irq_o` is low and `vec_o` reads 0000h.
- R2: A high cycle on `int_req_i[k]` sets pending bit k (bit 0 basic timer, 1 and 2 the timer/counters, 3 the watch timer) at that clock edge. The bit then stays set until software clears it.
- R3: A falling edge on `ext_irq_n_i[j]` sets pending bit 5+j on the third rising clock edge after the pin goes low. A rising edge, or a pin held low, sets nothing further.
- R4: Writing with `clr_we_i` clears each pending bit whose `clr_wdata_i` bit is 1 and leaves bits written 0 unchanged. A request arriving in the same cycle as the clear wins.
- R5: A maskable pending bit raises `irq_o` only while its enable bit (the same bit position of the value written with `en_we_i`) is 1 and `gie_o` is 1.
- R6: Pending bit 4 (speech, set by `speech_req_i`) raises `irq_o` whatever the enables and `gie_o` hold. Enable bit 4 is ignored.
- R7: While `irq_o` is high, `vec_o` reads 0018h if the speech source is requesting, and 0008h otherwise. The speech source has priority. While `irq_o` is low, `vec_o` reads 0000h.
- R8: `ack_i` while `irq_o` is high clears `gie_o` on that edge. `gie_set_i` sets it, but an acknowledge in the same cycle wins.
- R9: After a speech interrupt is acknowledged, the speech flag no longer raises `irq_o` until software clears pending bit 4. A later speech request is then taken again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_req_i | input | 4 | Internal maskable request pulses |
| speech_req_i | input | 1 | Speech (non-maskable) request pulse |
| ext_irq_n_i | input | 3 | Asynchronous active-low external requests |
| en_we_i | input | 1 | Write strobe for the per-source enables |
| en_wdata_i | input | 8 | Enable value, one bit per pending bit (bit 4 unused) |
| gie_set_i | input | 1 | Set the global enable |
| clr_we_i | input | 1 | Write strobe for the pending clear |
| clr_wdata_i | input | 8 | Write-one-to-clear mask for the pending flags |
| ack_i | input | 1 | CPU interrupt acknowledge |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 16 | Entry address for the current request |
| pend_o | output | 8 | Pending flags |
| gie_o | output | 1 | Global enable state |

## Verification
Directed sequences come first. They separate a flag that is pending but disabled from one that is enabled, show speech overriding a global enable that is off, and check the ordering when a set and a clear land in the same cycle. They also count the synchroniser latency on an external pin and confirm that rising or steady-low levels are ignored. A long random phase then mixes request pulses, pin toggles, enable writes, clears and acknowledges. This phase checks the shared-vector and non-maskable paths against each other when both are pending, and it covers the hold-off after a speech acknowledge while other sources keep firing.

// File: rtl/vic_pkg.sv
package vic_pkg;

   // which entry address the arbiter selects
   typedef enum logic [1:0] {
      VSEL_IDLE   = 2'd0,
      VSEL_SHARED = 2'd1,
      VSEL_NMI    = 2'd2
   } vsel_e;

   // pack the maskable flags (all but the speech bit) into one vector
   function automatic logic [15:0] drop_bit(input logic [15:0] v, input int pos);
      logic [15:0] r;
      r = '0;
      for (int i = 0; i < 16; i++) begin
         if (i < pos)      r[i]   = v[i];
         else if (i > pos) r[i-1] = v[i];
      end
      return r;
   endfunction

endpackage

// File: rtl/vic_ext_detect.sv
module vic_ext_detect #(
   parameter int N_PIN       = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit FALL_EDGE   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_PIN-1:0] pin_i,
   output logic [N_PIN-1:0] edge_o
);
   localparam logic IDLE_LVL = FALL_EDGE ? 1'b1 : 1'b0;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("vic_ext_detect: SYNC_STAGES must be at least 2");
   end

   for (genvar p = 0; p < N_PIN; p++) begin : g_pin
      logic [SYNC_STAGES-1:0] sync_q;
      logic                   prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sync_q <= {SYNC_STAGES{IDLE_LVL}};
            prev_q <= IDLE_LVL;
         end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i[p]};
            prev_q <= sync_q[SYNC_STAGES-1];
         end
      end

      if (FALL_EDGE) begin : g_fall
         assign edge_o[p] = prev_q & ~sync_q[SYNC_STAGES-1];
      end else begin : g_rise
         assign edge_o[p] = ~prev_q & sync_q[SYNC_STAGES-1];
      end
   end
endmodule

// File: rtl/vic_pend_bank.sv
module vic_pend_bank #(
   parameter int N_SRC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] set_i,
   input  logic             clr_we_i,
   input  logic [N_SRC-1:0] clr_i,
   output logic [N_SRC-1:0] pend_o
);
   for (genvar s = 0; s < N_SRC; s++) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flag_q <= 1'b0;
         else if (set_i[s])
            flag_q <= 1'b1;
         else if (clr_we_i && clr_i[s])
            flag_q <= 1'b0;
      end
      assign pend_o[s] = flag_q;
   end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
   import vic_pkg::*;
#(
   parameter int              N_MASK     = 7,
   parameter int              ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] IDLE_VEC   = 16'h0000,
   parameter logic [ADDR_W-1:0] SHARED_VEC = 16'h0008,
   parameter logic [ADDR_W-1:0] NMI_VEC    = 16'h0018
) (
   input  logic              nmi_pend_i,
   input  logic              nmi_busy_i,
   input  logic [N_MASK-1:0] mask_pend_i,
   input  logic [N_MASK-1:0] mask_en_i,
   input  logic              gie_i,
   output logic              irq_o,
   output vsel_e             vsel_o,
   output logic [ADDR_W-1:0] vec_o
);
   logic nmi_act;
   logic mask_act;

   assign nmi_act  = nmi_pend_i & ~nmi_busy_i;
   assign mask_act = gie_i & (|(mask_pend_i & mask_en_i));

   always_comb begin
      if (nmi_act)       vsel_o = VSEL_NMI;
      else if (mask_act) vsel_o = VSEL_SHARED;
      else               vsel_o = VSEL_IDLE;
   end

   assign irq_o = (vsel_o != VSEL_IDLE);

   always_comb begin
      unique case (vsel_o)
         VSEL_NMI:    vec_o = NMI_VEC;
         VSEL_SHARED: vec_o = SHARED_VEC;
         default:     vec_o = IDLE_VEC;
      endcase
   end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
   import vic_pkg::*;
#(
   parameter int N_INT       = 4,
   parameter int N_EXT       = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit EXT_FALL    = 1'b1,
   parameter int ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] IDLE_VEC   = 16'h0000,
   parameter logic [ADDR_W-1:0] SHARED_VEC = 16'h0008,
   parameter logic [ADDR_W-1:0] NMI_VEC    = 16'h0018,
   localparam int N_SRC  = N_INT + 1 + N_EXT,
   localparam int N_MASK = N_SRC - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_INT-1:0]  int_req_i,
   input  logic              speech_req_i,
   input  logic [N_EXT-1:0]  ext_irq_n_i,
   input  logic              en_we_i,
   input  logic [N_SRC-1:0]  en_wdata_i,
   input  logic              gie_set_i,
   input  logic              clr_we_i,
   input  logic [N_SRC-1:0]  clr_wdata_i,
   input  logic              ack_i,
   output logic              irq_o,
   output logic [ADDR_W-1:0] vec_o,
   output logic [N_SRC-1:0]  pend_o,
   output logic              gie_o
);
   localparam int SP_BIT = N_INT;

   if (N_INT < 1 || N_EXT < 1) begin : g_bad_count
      $error("vec_irq_ctrl: need at least one internal and one external source");
   end
   if (N_SRC > 16) begin : g_bad_width
      $error("vec_irq_ctrl: at most 16 sources supported");
   end

   logic [N_EXT-1:0]  ext_edge;
   logic [N_SRC-1:0]  set_vec;
   logic [N_MASK-1:0] en_q;
   logic [N_MASK-1:0] mask_pend;
   logic [15:0]       en_pack;
   logic [15:0]       pend_pack;
   logic              gie_q;
   logic              nmi_busy_q;
   logic              ack_take;
   vsel_e             vsel;

   vic_ext_detect #(
      .N_PIN      (N_EXT),
      .SYNC_STAGES(SYNC_STAGES),
      .FALL_EDGE  (EXT_FALL)
   ) i_ext (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (ext_irq_n_i),
      .edge_o(ext_edge)
   );

   assign set_vec = {ext_edge, speech_req_i, int_req_i};

   vic_pend_bank #(.N_SRC(N_SRC)) i_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_vec),
      .clr_we_i(clr_we_i),
      .clr_i   (clr_wdata_i),
      .pend_o  (pend_o)
   );

   assign en_pack   = drop_bit(16'(en_wdata_i), SP_BIT);
   assign pend_pack = drop_bit(16'(pend_o), SP_BIT);
   assign mask_pend = pend_pack[N_MASK-1:0];

   vic_arbiter #(
      .N_MASK    (N_MASK),
      .ADDR_W    (ADDR_W),
      .IDLE_VEC  (IDLE_VEC),
      .SHARED_VEC(SHARED_VEC),
      .NMI_VEC   (NMI_VEC)
   ) i_arb (
      .nmi_pend_i (pend_o[SP_BIT]),
      .nmi_busy_i (nmi_busy_q),
      .mask_pend_i(mask_pend),
      .mask_en_i  (en_q),
      .gie_i      (gie_q),
      .irq_o      (irq_o),
      .vsel_o     (vsel),
      .vec_o      (vec_o)
   );

   assign ack_take = ack_i & irq_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= '0;
         gie_q      <= 1'b0;
         nmi_busy_q <= 1'b0;
      end else begin
         if (en_we_i)
            en_q <= en_pack[N_MASK-1:0];
         if (ack_take)
            gie_q <= 1'b0;
         else if (gie_set_i)
            gie_q <= 1'b1;
         if (ack_take && vsel == VSEL_NMI)
            nmi_busy_q <= 1'b1;
         else if (clr_we_i && clr_wdata_i[SP_BIT])
            nmi_busy_q <= 1'b0;
      end
   end

   assign gie_o = gie_q;
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
   parameter int N_INT  = 4,
   parameter int N_SRC  = 8,
   parameter int ADDR_W = 16,
   parameter logic [ADDR_W-1:0] IDLE_VEC = 16'h0000,
   parameter logic [ADDR_W-1:0] NMI_VEC  = 16'h0018
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_INT-1:0]  int_req_i,
   input logic              ack_i,
   input logic              irq_o,
   input logic [ADDR_W-1:0] vec_o,
   input logic [N_SRC-1:0]  pend_o,
   input logic              gie_o,
   input logic              nmi_busy
);
   // R2
   int_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|int_req_i) |=> ((pend_o[N_INT-1:0] & $past(int_req_i)) == $past(int_req_i)));

   // R5
   mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !(pend_o[N_INT] && !nmi_busy)) |-> gie_o);

   // R6
   nmi_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o[N_INT] && !nmi_busy) |-> (irq_o && vec_o == NMI_VEC));

   // R7
   idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_o |-> (vec_o == IDLE_VEC));

   // R8
   ack_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o) |=> !gie_o);
endmodule

bind vec_irq_ctrl vic_chk #(
   .N_INT   (N_INT),
   .N_SRC   (N_SRC),
   .ADDR_W  (ADDR_W),
   .IDLE_VEC(IDLE_VEC),
   .NMI_VEC (NMI_VEC)
) i_vic_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .int_req_i(int_req_i),
   .ack_i    (ack_i),
   .irq_o    (irq_o),
   .vec_o    (vec_o),
   .pend_o   (pend_o),
   .gie_o    (gie_o),
   .nmi_busy (nmi_busy_q)
);

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  int_req = '0;
   logic        speech = 1'b0;
   logic [2:0]  ext_n = 3'b111;
   logic        en_we = 1'b0;
   logic [7:0]  en_wd = '0;
   logic        gie_set = 1'b0;
   logic        clr_we = 1'b0;
   logic [7:0]  clr_wd = '0;
   logic        ack = 1'b0;
   logic        irq;
   logic [15:0] vec;
   logic [7:0]  pend;
   logic        gie;

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;

   // bench reference state
   logic [7:0] m_pend;
   logic [6:0] m_en;
   logic       m_gie, m_busy;
   logic [2:0] m_s0, m_s1, m_s2;

   always #2 clk = ~clk;

   vec_irq_ctrl i_vec_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .int_req_i(int_req), .speech_req_i(speech),
      .ext_irq_n_i(ext_n), .en_we_i(en_we), .en_wdata_i(en_wd),
      .gie_set_i(gie_set), .clr_we_i(clr_we), .clr_wdata_i(clr_wd),
      .ack_i(ack), .irq_o(irq), .vec_o(vec), .pend_o(pend), .gie_o(gie));

   function automatic logic f_nmi();
      return m_pend[4] & ~m_busy;
   endfunction

   function automatic logic f_irq();
      return f_nmi() | (m_gie & (|({m_pend[7:5], m_pend[3:0]} & m_en)));
   endfunction

   function automatic logic [15:0] f_vec();
      if (f_nmi()) return 16'h0018;
      if (f_irq()) return 16'h0008;
      return 16'h0000;
   endfunction

   task automatic chk(input string req, input string what, input logic [15:0] act,
                      input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic model_reset();
      m_pend = '0; m_en = '0; m_gie = 0; m_busy = 0;
      m_s0 = 3'b111; m_s1 = 3'b111; m_s2 = 3'b111;
   endtask

   // one clock: update model at the edge, compare at the falling edge
   task automatic step();
      logic       ackt, nmi;
      logic [2:0] fall;
      logic [7:0] setv, clrm;
      @(posedge clk);
      cyc++;
      nmi  = f_nmi();
      ackt = ack & f_irq();
      fall = m_s2 & ~m_s1;
      m_s2 = m_s1; m_s1 = m_s0; m_s0 = ext_n;
      setv = {fall, speech, int_req};
      clrm = clr_we ? clr_wd : 8'h00;
      if (ackt && nmi) m_busy = 1'b1;
      else if (clrm[4]) m_busy = 1'b0;
      m_pend = (m_pend & ~clrm) | setv;
      if (en_we) m_en = {en_wd[7:5], en_wd[3:0]};
      if (ackt) m_gie = 1'b0;
      else if (gie_set) m_gie = 1'b1;
      @(negedge clk);
      chk("R2", "pend", 16'(pend), 16'(m_pend));
      chk("R5", "irq", 16'(irq), 16'(f_irq()));
      chk("R7", "vec", vec, f_vec());
      chk("R8", "gie", 16'(gie), 16'(m_gie));
   endtask

   task automatic idle_in();
      int_req = '0; speech = 0; en_we = 0; gie_set = 0; clr_we = 0; ack = 0;
   endtask

   always @(posedge clk) begin
      if (cyc > 100000) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1", "pend", 16'(pend), 16'h0);
      chk("R1", "irq", 16'(irq), 16'h0);
      chk("R1", "vec", vec, 16'h0000);
      chk("R1", "gie", 16'(gie), 16'h0);

      // R2 internal pulse on TC1 (bit 2), disabled -> no irq (R5)
      int_req = 4'b0100; step(); idle_in();
      chk("R2", "pend set", 16'(pend), 16'h04);
      step();
      chk("R2", "pend held", 16'(pend), 16'h04);
      chk("R5", "irq without enable", 16'(irq), 16'h0);
      // enable only, no global enable
      en_we = 1; en_wd = 8'h04; step(); idle_in();
      chk("R5", "irq without gie", 16'(irq), 16'h0);
      gie_set = 1; step(); idle_in();
      chk("R5", "irq enabled", 16'(irq), 16'h1);
      chk("R7", "shared vec", vec, 16'h0008);
      // R8 ack with concurrent gie_set: ack wins
      ack = 1; gie_set = 1; step(); idle_in();
      chk("R8", "gie after ack", 16'(gie), 16'h0);
      chk("R8", "irq after ack", 16'(irq), 16'h0);
      // R4 clear with zero mask leaves, one clears
      clr_we = 1; clr_wd = 8'h00; step(); idle_in();
      chk("R4", "zero mask", 16'(pend), 16'h04);
      clr_we = 1; clr_wd = 8'h04; step(); idle_in();
      chk("R4", "w1c", 16'(pend), 16'h00);
      // R4 set wins over clear
      int_req = 4'b0001; clr_we = 1; clr_wd = 8'h01; step(); idle_in();
      chk("R4", "set beats clear", 16'(pend), 16'h01);
      clr_we = 1; clr_wd = 8'h01; step(); idle_in();

      // R6 speech with gie low and enable bit 4 set ignored
      en_we = 1; en_wd = 8'h10; step(); idle_in();
      chk("R6", "enable bit4 no effect", 16'(irq), 16'h0);
      speech = 1; int_req = 4'b1000; step(); idle_in();
      chk("R6", "nmi irq", 16'(irq), 16'h1);
      chk("R7", "nmi vec", vec, 16'h0018);
      // R9 ack holds speech off
      ack = 1; step(); idle_in();
      chk("R9", "nmi held off", 16'(irq), 16'h0);
      chk("R9", "flag still set", 16'(pend), 16'h18);
      step();
      chk("R9", "still held", 16'(irq), 16'h0);
      clr_we = 1; clr_wd = 8'h10; step(); idle_in();
      speech = 1; step(); idle_in();
      chk("R9", "nmi retaken", vec, 16'h0018);
      clr_we = 1; clr_wd = 8'hFF; step(); idle_in();

      // R3 external pin 1 falling edge: set on third edge
      ext_n = 3'b101;
      step(); chk("R3", "edge 1", 16'(pend), 16'h00);
      step(); chk("R3", "edge 2", 16'(pend), 16'h00);
      step(); chk("R3", "edge 3", 16'(pend), 16'h40);
      clr_we = 1; clr_wd = 8'h40; step(); idle_in();
      repeat (4) step();
      chk("R3", "held low", 16'(pend), 16'h00);
      ext_n = 3'b111;
      repeat (4) step();
      chk("R3", "rising edge", 16'(pend), 16'h00);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         int_req = ($urandom % 8 == 0) ? 4'($urandom) : 4'h0;
         speech  = ($urandom % 40 == 0);
         if ($urandom % 6 == 0) ext_n = 3'($urandom);
         en_we   = ($urandom % 25 == 0); en_wd = 8'($urandom);
         gie_set = ($urandom % 10 == 0);
         clr_we  = ($urandom % 5 == 0);  clr_wd = 8'($urandom);
         ack     = ($urandom % 6 == 0);
         step();
      end
      idle_in();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule